// File: doc/BRIEF.md
# Per-Pin Interrupt Acceptance and Delivery Engine

This block sits between a set of raw interrupt lines and a processor-side interrupt fabric. Every input pin is fed by several independent sources, and the pin's line level is the OR of their assertion bits. For each pin the block keeps one pending-request bit. Using that pin's routing entry, it decides whether a new assertion becomes a delivery request, is folded into one already outstanding (coalesced), or is held back by the mask. The entry supplies polarity, trigger mode, mask, remote-IRR flag, vector and destination fields. The routing table itself is stored outside the block. The block reads all entries in parallel and sends back per-pin set and clear strobes for the remote-IRR flag.

End-of-interrupt notifications arrive with a vector. In level mode every level-triggered pin whose entry carries that vector gets its remote-IRR flag cleared. If such a pin is still requesting and unmasked, it is queued again. Queued pins leave one per accepted handshake, lowest pin number first. Each request is presented as a valid/ready transfer that carries the entry's routing fields, a fixed level of 1 and no shorthand. Every line event produces a status code on the following cycle.

Top module: `irq_dlv_top`

## Requirements
- R1: A pin's line level is the OR of its per-source bits. A line event writes one source's bit on one pin. A clear-source command zeroes that source's bit on every pin and changes no request bit. When both arrive in the same cycle, the clear is applied first and the event second.
- R2: The effective level is the line level XOR the entry's act_low bit (1 = active low). An event whose effective level is inactive clears the pin's request bit and reports status 0 (accepted).
- R3: On an edge pin (lvl_trig = 0), an active event queues a delivery only when the request bit goes from 0 to 1. If the request bit was already set, the event reports status 1 (coalesced).
- R4: On a level pin (lvl_trig = 1), an active event sets the request bit. It queues a delivery only when three things hold: the remote-IRR flag is clear, no delivery for that pin is queued, and no re-delivery for that pin is being queued in the same cycle. Otherwise it reports status 1.
- R5: A masked entry never presents a delivery. An active event that is not coalesced on a masked pin reports status 2 (masked). A queued request whose entry becomes masked is dropped.
- R6: When a delivery of a level pin is accepted (valid and ready both high), rirr_set carries that pin's bit in the same cycle.
- R7: A level-mode EOI pulses rirr_clr for every level pin whose entry vector equals the EOI vector, not only the first match. Each such pin that is unmasked, has its request bit set and has nothing queued is queued again.
- R8: An EOI with eoi_level = 0 clears no remote-IRR flag and queues nothing.
- R9: Queued pins are presented lowest pin number first, one per accepted handshake. dlv_valid stays high until ready unless the mask changes.
- R10: A request copies vector, destination, destination mode, delivery mode and trigger mode from the pin's entry, and always carries dlv_level = 1 and dlv_shorthand = 0. The entry is packed MSB first: dest[7:0], mask, lvl_trig, rirr, act_low, dest_logical, dmod[2:0], vec[7:0]. Pin p occupies tbl_flat[24p+23:24p].
- R11: When an EOI and a line event hit the same pin in one cycle, the EOI is processed first, and the event sees its cleared flag and any re-delivery it queued.
- R12: The status for a line event appears one cycle after the event. After reset no request is pending, no delivery is valid and no status is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_valid | input | 1 | Line event strobe |
| ln_pin | input | 3 | Pin of the line event |
| ln_src | input | 2 | Source of the line event |
| ln_level | input | 1 | New assertion bit of that source |
| clr_valid | input | 1 | Clear-source command strobe |
| clr_src | input | 2 | Source to clear on all pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-mode EOI |
| tbl_flat | input | 192 | All routing entries, packed |
| rirr_set | output | 8 | Per-pin remote-IRR set strobe |
| rirr_clr | output | 8 | Per-pin remote-IRR clear strobe |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_pin | output | 3 | Pin being delivered |
| dlv_vec | output | 8 | Vector |
| dlv_dest | output | 8 | Destination |
| dlv_dest_logical | output | 1 | Destination mode |
| dlv_dmod | output | 3 | Delivery mode |
| dlv_lvl_trig | output | 1 | Trigger mode |
| dlv_level | output | 1 | Level, always 1 |
| dlv_shorthand | output | 2 | Shorthand, always 0 |
| st_valid | output | 1 | Status valid |
| st_pin | output | 3 | Pin of the status |
| st_code | output | 2 | 0 accepted, 1 coalesced, 2 masked |

## Verification
The bench targets the following corner cases. A second source holds a line high after the first deasserts; a design that does not OR the sources would drop the request bit, and a later assertion would wrongly deliver. A repeated edge assertion must be coalesced; a design that acts on level instead of the transition would deliver twice. A level-mode EOI shares its vector between two pins; a design that stops at the first match would leave the second pin's remote-IRR flag stuck and never re-deliver it. An EOI and an assertion on the same level pin arrive in one cycle; if the assertion were processed first, the pin would be delivered twice or its status would differ.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DMOD_W = 3;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              lvl_trig;
        logic              rirr;
        logic              act_low;
        logic              dest_logical;
        logic [DMOD_W-1:0] dmod;
        logic [VEC_W-1:0]  vec;
    } rte_t;

    localparam int RTE_W = $bits(rte_t);

    typedef enum logic [1:0] {
        ST_ACCEPT    = 2'd0,
        ST_COALESCED = 2'd1,
        ST_MASKED    = 2'd2
    } stat_e;
endpackage

// File: rtl/irq_src_lines.sv
module irq_src_lines #(
    parameter int NPINS = 8,
    parameter int NSRC  = 4,
    localparam int PIN_W = $clog2(NPINS),
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [PIN_W-1:0] ev_pin,
    input  logic [SRC_W-1:0] ev_src,
    input  logic             ev_level,
    input  logic             clr_valid,
    input  logic [SRC_W-1:0] clr_src,
    output logic             line_now
);
    logic [NSRC-1:0] bits_q [NPINS];
    logic [NSRC-1:0] bits_d [NPINS];

    always_comb begin
        line_now = 1'b0;
        for (int p = 0; p < NPINS; p++) begin
            bits_d[p] = bits_q[p];
            if (clr_valid) bits_d[p][clr_src] = 1'b0;
            if (ev_valid && ev_pin == PIN_W'(p)) bits_d[p][ev_src] = ev_level;
            if (ev_pin == PIN_W'(p)) line_now = |bits_d[p];
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPINS; p++) begin
            if (rst) bits_q[p] <= '0;
            else     bits_q[p] <= bits_d[p];
        end
    end
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match
    import irq_dlv_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             eoi_level,
    input  rte_t             ent [NPINS],
    input  logic [NPINS-1:0] irr,
    input  logic [NPINS-1:0] pend,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] redeliver
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign hit[p] = eoi_valid && eoi_level && ent[p].lvl_trig &&
                        (ent[p].vec == eoi_vec);
        assign redeliver[p] = hit[p] && !ent[p].mask && irr[p] && !pend[p];
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_dlv_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PIN_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [PIN_W-1:0] ev_pin,
    input  logic             line_now,
    input  rte_t             ent [NPINS],
    input  logic [NPINS-1:0] rirr_eff,
    input  logic [NPINS-1:0] pend_cur,
    input  logic [NPINS-1:0] redeliver,
    output logic [NPINS-1:0] irr,
    output logic [NPINS-1:0] new_req,
    output logic             st_valid,
    output logic [PIN_W-1:0] st_pin,
    output stat_e            st_code
);
    rte_t             sel;
    logic             old_irr, busy, eff;
    logic [NPINS-1:0] irr_d;
    stat_e            code;

    always_comb begin
        sel     = '0;
        old_irr = 1'b0;
        busy    = 1'b0;
        for (int p = 0; p < NPINS; p++) begin
            if (ev_pin == PIN_W'(p)) begin
                sel     = ent[p];
                old_irr = irr[p];
                busy    = rirr_eff[p] | pend_cur[p] | redeliver[p];
            end
        end
        eff     = line_now ^ sel.act_low;
        irr_d   = irr;
        new_req = '0;
        code    = ST_ACCEPT;
        if (ev_valid) begin
            if (!eff) begin
                irr_d[ev_pin] = 1'b0;
            end else begin
                irr_d[ev_pin] = 1'b1;
                if (sel.lvl_trig ? busy : old_irr) code = ST_COALESCED;
                else if (sel.mask)                 code = ST_MASKED;
                else                               new_req[ev_pin] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr      <= '0;
            st_valid <= 1'b0;
            st_pin   <= '0;
            st_code  <= ST_ACCEPT;
        end else begin
            irr      <= irr_d;
            st_valid <= ev_valid;
            st_pin   <= ev_pin;
            st_code  <= code;
        end
    end

    // R3: an edge assertion on an already requesting pin is coalesced
    p_edge_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        ev_valid && eff && !sel.lvl_trig && old_irr |=> st_code == ST_COALESCED);

    // R4: a level assertion while a delivery is outstanding is coalesced
    p_level_busy_r4: assert property (@(posedge clk) disable iff (rst)
        ev_valid && eff && sel.lvl_trig && busy |=> st_code == ST_COALESCED);

    // R2: an inactive event leaves the request bit clear
    p_inactive_clear_r2: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !eff |=> !irr[$past(ev_pin)] && st_code == ST_ACCEPT);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dlv_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PIN_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  rte_t             ent [NPINS],
    input  logic [NPINS-1:0] mask_vec,
    input  logic [NPINS-1:0] set_req,
    input  logic             dlv_ready,
    output logic [NPINS-1:0] pend,
    output logic [NPINS-1:0] grant,
    output logic             dlv_valid,
    output logic [PIN_W-1:0] dlv_pin,
    output rte_t             sel_ent
);
    logic [NPINS-1:0] cand;

    always_comb begin
        cand    = pend & ~mask_vec;
        dlv_pin = '0;
        sel_ent = ent[0];
        for (int p = NPINS - 1; p >= 0; p--) begin
            if (cand[p]) begin
                dlv_pin = PIN_W'(p);
                sel_ent = ent[p];
            end
        end
        dlv_valid = |cand;
        grant     = '0;
        if (dlv_valid && dlv_ready) grant[dlv_pin] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= ((pend & ~grant) | set_req) & ~mask_vec;
    end

    // R9: at most one pin granted per cycle
    p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R9: a waiting request stays valid unless the mask changed
    p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
        dlv_valid && !dlv_ready |=> dlv_valid || !$stable(mask_vec));

    // R5: the presented pin is never masked
    p_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> !mask_vec[dlv_pin]);
endmodule

// File: rtl/irq_dlv_top.sv
module irq_dlv_top
    import irq_dlv_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int NSRC  = 4,
    localparam int PIN_W = $clog2(NPINS),
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ln_valid,
    input  logic [PIN_W-1:0]       ln_pin,
    input  logic [SRC_W-1:0]       ln_src,
    input  logic                   ln_level,
    input  logic                   clr_valid,
    input  logic [SRC_W-1:0]       clr_src,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vec,
    input  logic                   eoi_level,
    input  logic [NPINS*RTE_W-1:0] tbl_flat,
    output logic [NPINS-1:0]       rirr_set,
    output logic [NPINS-1:0]       rirr_clr,
    output logic                   dlv_valid,
    input  logic                   dlv_ready,
    output logic [PIN_W-1:0]       dlv_pin,
    output logic [VEC_W-1:0]       dlv_vec,
    output logic [DEST_W-1:0]      dlv_dest,
    output logic                   dlv_dest_logical,
    output logic [DMOD_W-1:0]      dlv_dmod,
    output logic                   dlv_lvl_trig,
    output logic                   dlv_level,
    output logic [1:0]             dlv_shorthand,
    output logic                   st_valid,
    output logic [PIN_W-1:0]       st_pin,
    output logic [1:0]             st_code
);
    rte_t             ent [NPINS];
    logic [NPINS-1:0] mask_vec, trig_vec, rirr_vec;
    logic [NPINS-1:0] irr, pend, grant, hit, redeliver, new_req, rirr_eff;
    logic             line_now;
    rte_t             sel_ent;
    stat_e            code;

    for (genvar p = 0; p < NPINS; p++) begin : g_ent
        assign ent[p]      = rte_t'(tbl_flat[p*RTE_W +: RTE_W]);
        assign mask_vec[p] = ent[p].mask;
        assign trig_vec[p] = ent[p].lvl_trig;
        assign rirr_vec[p] = ent[p].rirr;
    end

    irq_src_lines #(.NPINS(NPINS), .NSRC(NSRC)) u_lines (
        .clk(clk), .rst(rst),
        .ev_valid(ln_valid), .ev_pin(ln_pin), .ev_src(ln_src), .ev_level(ln_level),
        .clr_valid(clr_valid), .clr_src(clr_src),
        .line_now(line_now)
    );

    irq_eoi_match #(.NPINS(NPINS)) u_eoi (
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level),
        .ent(ent), .irr(irr), .pend(pend),
        .hit(hit), .redeliver(redeliver)
    );

    assign rirr_eff = rirr_vec & ~hit;

    irq_accept #(.NPINS(NPINS)) u_acc (
        .clk(clk), .rst(rst),
        .ev_valid(ln_valid), .ev_pin(ln_pin), .line_now(line_now),
        .ent(ent), .rirr_eff(rirr_eff), .pend_cur(pend), .redeliver(redeliver),
        .irr(irr), .new_req(new_req),
        .st_valid(st_valid), .st_pin(st_pin), .st_code(code)
    );

    irq_dispatch #(.NPINS(NPINS)) u_dsp (
        .clk(clk), .rst(rst),
        .ent(ent), .mask_vec(mask_vec), .set_req(new_req | redeliver),
        .dlv_ready(dlv_ready),
        .pend(pend), .grant(grant),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .sel_ent(sel_ent)
    );

    assign st_code          = code;
    assign rirr_set         = grant & trig_vec;
    assign rirr_clr         = hit & ~rirr_set;
    assign dlv_vec          = sel_ent.vec;
    assign dlv_dest         = sel_ent.dest;
    assign dlv_dest_logical = sel_ent.dest_logical;
    assign dlv_dmod         = sel_ent.dmod;
    assign dlv_lvl_trig     = sel_ent.lvl_trig;
    assign dlv_level        = 1'b1;
    assign dlv_shorthand    = 2'b00;

    // R6: a remote-IRR set only comes from an accepted level delivery
    p_rirr_set_hs_r6: assert property (@(posedge clk) disable iff (rst)
        |rirr_set |-> dlv_valid && dlv_ready && dlv_lvl_trig);

    // R8: an edge-mode EOI clears nothing
    p_edge_eoi_r8: assert property (@(posedge clk) disable iff (rst)
        eoi_valid && !eoi_level |-> rirr_clr == '0);
endmodule

// File: tb/irq_dlv_top_test.sv
`timescale 1ns/1ps
module irq_dlv_top_test;
    import irq_dlv_pkg::*;

    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             ln_valid = 0, ln_level = 0, clr_valid = 0;
    logic [2:0]       ln_pin = 0;
    logic [1:0]       ln_src = 0, clr_src = 0;
    logic             eoi_valid = 0, eoi_level = 0, dlv_ready = 1;
    logic [7:0]       eoi_vec = 0;
    logic [NP*RTE_W-1:0] tbl_flat;
    logic [NP-1:0]    rirr_set, rirr_clr;
    logic             dlv_valid, dlv_dest_logical, dlv_lvl_trig, dlv_level, st_valid;
    logic [2:0]       dlv_pin, dlv_dmod, st_pin;
    logic [7:0]       dlv_vec, dlv_dest;
    logic [1:0]       dlv_shorthand, st_code;

    rte_t tb [NP];
    always_comb for (int p = 0; p < NP; p++) tbl_flat[p*RTE_W +: RTE_W] = tb[p];

    irq_dlv_top uut (
        .clk(clk), .rst(rst),
        .ln_valid(ln_valid), .ln_pin(ln_pin), .ln_src(ln_src), .ln_level(ln_level),
        .clr_valid(clr_valid), .clr_src(clr_src),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level),
        .tbl_flat(tbl_flat), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
        .dlv_vec(dlv_vec), .dlv_dest(dlv_dest), .dlv_dest_logical(dlv_dest_logical),
        .dlv_dmod(dlv_dmod), .dlv_lvl_trig(dlv_lvl_trig), .dlv_level(dlv_level),
        .dlv_shorthand(dlv_shorthand),
        .st_valid(st_valid), .st_pin(st_pin), .st_code(st_code)
    );

    int    n_chk = 0, n_err = 0;
    string cur_req = "R12";

    // reference model state
    logic [3:0]  m_bits [NP];
    logic [NP-1:0] m_irr, m_pend;
    logic        e_stv;
    int          e_stp, e_stc;
    // planned next state
    logic [3:0]  n_bits [NP];
    logic [NP-1:0] n_irr, n_pend, n_rset, n_rclr;
    logic        n_stv;
    int          n_stp, n_stc;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic plan();
        logic [NP-1:0] hit, redel;
        logic ev, gr, line, eff, busy;
        int   ep;
        rte_t e;
        ev = 0; ep = 0;
        for (int p = 0; p < NP; p++) begin
            hit[p]   = eoi_valid && eoi_level && tb[p].lvl_trig && tb[p].vec == eoi_vec;
            redel[p] = hit[p] && !tb[p].mask && m_irr[p] && !m_pend[p];
        end
        for (int p = 0; p < NP; p++)
            if (!ev && m_pend[p] && !tb[p].mask) begin ev = 1; ep = p; end
        gr = ev && dlv_ready;
        for (int p = 0; p < NP; p++) begin
            n_rset[p] = gr && ep == p && tb[p].lvl_trig;
            n_rclr[p] = hit[p] && !n_rset[p];
        end
        chk("dlv_valid", int'(dlv_valid), int'(ev));
        if (ev) begin
            chk("dlv_pin", int'(dlv_pin), ep);
            chk("dlv_vec", int'(dlv_vec), int'(tb[ep].vec));
            chk("dlv_dest", int'(dlv_dest), int'(tb[ep].dest));
            chk("dlv_dmode", int'(dlv_dest_logical), int'(tb[ep].dest_logical));
            chk("dlv_dmod", int'(dlv_dmod), int'(tb[ep].dmod));
            chk("dlv_trig", int'(dlv_lvl_trig), int'(tb[ep].lvl_trig));
            chk("dlv_level", int'(dlv_level), 1);
            chk("dlv_shorthand", int'(dlv_shorthand), 0);
        end
        chk("rirr_set", int'(rirr_set), int'(n_rset));
        chk("rirr_clr", int'(rirr_clr), int'(n_rclr));
        chk("st_valid", int'(st_valid), int'(e_stv));
        if (e_stv) begin
            chk("st_pin", int'(st_pin), e_stp);
            chk("st_code", int'(st_code), e_stc);
        end
        // next state
        for (int p = 0; p < NP; p++) begin
            n_bits[p] = m_bits[p];
            if (clr_valid) n_bits[p][clr_src] = 1'b0;
            n_pend[p] = (m_pend[p] && !(gr && ep == p)) || redel[p];
        end
        n_irr = m_irr;
        n_stv = ln_valid; n_stp = int'(ln_pin); n_stc = 0;
        if (ln_valid) begin
            n_bits[ln_pin][ln_src] = ln_level;
            line = |n_bits[ln_pin];
            e    = tb[ln_pin];
            eff  = line ^ e.act_low;
            busy = (e.rirr && !hit[ln_pin]) || m_pend[ln_pin] || redel[ln_pin];
            if (!eff) n_irr[ln_pin] = 0;
            else begin
                if (e.lvl_trig ? busy : m_irr[ln_pin]) n_stc = 1;
                else if (e.mask) n_stc = 2;
                else n_pend[ln_pin] = 1;
                n_irr[ln_pin] = 1;
            end
        end
        for (int p = 0; p < NP; p++) if (tb[p].mask) n_pend[p] = 0;
    endtask

    task automatic commit();
        for (int p = 0; p < NP; p++) begin
            m_bits[p] = rst ? 4'h0 : n_bits[p];
            tb[p].rirr = rst ? 1'b0 : ((tb[p].rirr && !n_rclr[p]) || n_rset[p]);
        end
        m_irr  = rst ? '0 : n_irr;
        m_pend = rst ? '0 : n_pend;
        e_stv  = rst ? 1'b0 : n_stv;
        e_stp  = n_stp;
        e_stc  = n_stc;
    endtask

    task automatic step();
        @(negedge clk);
        plan();
        @(posedge clk);
        commit();
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_line(int p, int s, logic l);
        ln_valid = 1; ln_pin = 3'(p); ln_src = 2'(s); ln_level = l;
        step();
        ln_valid = 0;
    endtask

    task automatic do_clr(int s);
        clr_valid = 1; clr_src = 2'(s);
        step();
        clr_valid = 0;
    endtask

    task automatic do_eoi(int v, logic l);
        eoi_valid = 1; eoi_vec = 8'(v); eoi_level = l;
        step();
        eoi_valid = 0;
    endtask

    initial begin
        #(200000 * 5.0);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            tb[p] = '0;
            tb[p].mask = 1'b1;
            tb[p].vec  = 8'(8'h20 + p);
            tb[p].dest = 8'(p + 1);
            m_bits[p] = '0;
        end
        m_irr = '0; m_pend = '0; e_stv = 0; e_stp = 0; e_stc = 0;
        // R12: reset state
        cur_req = "R12";
        rst = 1; idle(3);
        rst = 0; idle(2);

        // R3: edge pin, repeated assertion is coalesced
        cur_req = "R3";
        tb[2].mask = 0; tb[2].dest_logical = 1; tb[2].dmod = 3'd5;
        do_line(2, 0, 1); idle(2);
        do_line(2, 1, 1); idle(2);
        // R1: second source keeps the line high
        cur_req = "R1";
        do_line(2, 0, 0); idle(1);
        do_line(2, 0, 1); idle(2);
        // R2: line low clears request, re-assert delivers again
        cur_req = "R2";
        do_line(2, 0, 0); do_line(2, 1, 0); idle(1);
        cur_req = "R3";
        do_line(2, 1, 1); idle(2);

        // R1: clear-source drops one source on every pin
        cur_req = "R1";
        tb[3].mask = 0; tb[4].mask = 0;
        do_line(3, 2, 1); do_line(4, 2, 1); idle(2);
        do_clr(2);
        do_line(3, 0, 0); do_line(4, 1, 0); idle(1);
        ln_valid = 1; ln_pin = 3'd3; ln_src = 2'd1; ln_level = 1;
        clr_valid = 1; clr_src = 2'd1;
        step();
        ln_valid = 0; clr_valid = 0; idle(2);

        // R2: active-low pin
        cur_req = "R2";
        tb[5].mask = 0; tb[5].act_low = 1;
        do_line(5, 0, 1); idle(1);
        do_line(5, 0, 0); idle(2);

        // R4 / R6: level pin with remote-IRR interlock
        cur_req = "R4";
        tb[6].mask = 0; tb[6].lvl_trig = 1; tb[6].vec = 8'h40;
        tb[1].mask = 0; tb[1].lvl_trig = 1; tb[1].vec = 8'h40;
        do_line(6, 0, 1); cur_req = "R6"; idle(2);
        cur_req = "R4";
        do_line(6, 1, 1); idle(1);
        do_line(1, 0, 1); idle(2);

        // R8: edge-mode EOI has no effect
        cur_req = "R8";
        do_eoi(8'h40, 0); idle(2);
        do_line(6, 2, 1); idle(1);

        // R7 / R9: level EOI hits both pins, ascending order, held valid
        cur_req = "R7";
        dlv_ready = 0;
        do_eoi(8'h40, 1);
        cur_req = "R9";
        idle(3);
        dlv_ready = 1; idle(1);
        dlv_ready = 0; idle(2);
        dlv_ready = 1; idle(2);

        // R11: EOI and line event on the same level pin in one cycle
        cur_req = "R11";
        eoi_valid = 1; eoi_vec = 8'h40; eoi_level = 1;
        ln_valid = 1; ln_pin = 3'd6; ln_src = 2'd3; ln_level = 1;
        step();
        eoi_valid = 0; ln_valid = 0; idle(4);

        // R5: masked pins never deliver; queued request dropped on mask
        cur_req = "R5";
        tb[7].lvl_trig = 1;
        do_line(7, 0, 1); idle(2);
        tb[0].mask = 0;
        dlv_ready = 0;
        do_line(0, 0, 1); idle(1);
        tb[0].mask = 1; idle(1);
        tb[0].mask = 0; dlv_ready = 1; idle(2);
        do_line(0, 1, 1); idle(1);
        tb[0].mask = 1;
        do_line(0, 0, 0); do_line(0, 1, 0); do_line(0, 2, 1); idle(2);

        // R10: fields checked on a deliberately varied entry
        cur_req = "R10";
        tb[4].dest = 8'hA5; tb[4].dmod = 3'd7; tb[4].dest_logical = 1;
        do_line(4, 3, 1); idle(2);

        // R12: back to reset state
        cur_req = "R12";
        rst = 1; idle(2);
        rst = 0; idle(2);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule